// File: doc/BRIEF.md
# Interrupt Recognition and Vector Unit

This unit is the interrupt front end of a small processor core. It captures the interrupt request lines on the falling edge of the core clock. At each instruction boundary it decides whether the instruction about to start runs or is replaced by an interrupt. When it takes one, it suppresses that instruction and saves the instruction's address on an internal return stack. It then spends two cycles calling the handler and clears the global interrupt enable. The handler address is made from a base register and the number of the winning source.

The core's decoder tells the unit three things: where each instruction begins, whether a boundary is only an extra fetch inside a long instruction, and when a return-from-interrupt or an enable instruction runs. The unit answers with a suppress strobe, a stack push strobe with the saved address, and a program counter load with its target. It also drives the enable flag and a sticky stack overflow flag. A request that misses the sampling edge before a boundary waits for the next boundary, so the shortest response is two and a half clock cycles.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `gie`, `insn_kill`, `push_strobe`, `pc_load` and `stk_ovf` are all 0.
- R2: Request lines are captured only on the falling clock edge. A request that rises after one falling edge and drops before the next one is never taken.
- R3: An interrupt is taken at a rising edge only when all of these hold: `insn_boundary` is 1, `insn_multi` is 0, `reti` is 0, the unit is idle, `gie` is 1, and at least one captured request has its `irq_mask` bit at 1. A boundary with `insn_multi` at 1 never takes one.
- R4: When several unmasked requests are captured, the lowest-numbered source wins. A source whose mask bit is 0 is never chosen.
- R5: In the cycle after the deciding edge, `insn_kill` and `push_strobe` are 1 for exactly one cycle. `push_addr` then equals the `next_pc` value present at the deciding edge.
- R6: In the cycle after that, `pc_load` is 1 for one cycle with `pc_new` = {`ibase`, 3-bit source number, 2'b00}, using the `ibase` value and the winner at the deciding edge. Boundaries during these two call cycles are ignored.
- R7: Taking an interrupt makes `gie` read 0 from the next cycle on. `ei` in an idle cycle with no take and no `reti` makes `gie` read 1 from the next cycle on. While `gie` is 0, no interrupt is taken.
- R8: `reti` in an idle cycle sets `gie`. If the stack is not empty, the next cycle shows `pc_load` = 1 with `pc_new` equal to the most recently pushed address, and that entry is removed. On an empty stack, only `gie` changes.
- R9: A push while the stack already holds `STACK_DEPTH` entries is dropped and sets `stk_ovf`. The flag stays at 1 until reset, and the stored entries are not changed.
- R10: When `reti` coincides with a boundary that would otherwise take an interrupt, the return is done and no interrupt is taken at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; requests captured on falling edge, decisions on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Interrupt request lines, bit i = source i |
| irq_mask | input | 8 | Per-source enable, 1 = source may interrupt |
| insn_boundary | input | 1 | Next rising edge starts an instruction |
| insn_multi | input | 1 | The boundary is an extra byte fetch of a long instruction |
| reti | input | 1 | Return-from-interrupt executes |
| ei | input | 1 | Enable-interrupts instruction executes |
| next_pc | input | 16 | Address of the instruction about to start |
| ibase | input | 11 | Interrupt base register |
| insn_kill | output | 1 | Suppress the pending instruction |
| push_strobe | output | 1 | Return address pushed this cycle |
| push_addr | output | 16 | Address being pushed |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Handler vector or return address |
| gie | output | 1 | Global interrupt enable |
| stk_ovf | output | 1 | Sticky return stack overflow |

## Verification
The bench targets four corner cases:
- A request pulse that lives only between a falling and a rising edge. A unit that sampled on the rising edge would take it.
- Competing sources with the lower one masked off. A wrong priority or masking order would show a different source number in the vector.
- A return in the same cycle as a qualifying boundary. A design that let the interrupt win would push twice and lose the return.
- A fifth nested push into a four-entry stack. A unit that overwrote the top entry would return to the wrong address, and one that wrapped would corrupt the oldest entry.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int unsigned N_SRC  = 8;
    parameter int unsigned TYPE_W = $clog2(N_SRC);
    parameter int unsigned LOW_W  = 2;
    parameter int unsigned PC_W   = 16;
    parameter int unsigned BASE_W = PC_W - TYPE_W - LOW_W;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [N_SRC-1:0]  src_t;
    typedef logic [TYPE_W-1:0] type_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALL_A = 2'd1,
        ST_CALL_B = 2'd2,
        ST_RET    = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic  valid;
        type_t kind;
    } pick_t;

    typedef struct packed {
        pc_t ret;
        pc_t vec;
    } call_ctx_t;

    // fixed priority: lowest index wins
    function automatic pick_t pick_lowest(src_t pend);
        pick_t r;
        r.valid = 1'b0;
        r.kind  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                r.valid = 1'b1;
                r.kind  = type_t'(i);
            end
        end
        return r;
    endfunction

    function automatic pc_t build_vector(base_t b, type_t k);
        return {b, k, {LOW_W{1'b0}}};
    endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  src_t  req,
    input  src_t  mask,
    output pick_t pick
);
    src_t smp_q;

    // capture on the falling edge; the following rising edge decides
    always_ff @(negedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= req;
    end

    always_comb begin
        pick = pick_lowest(smp_q & mask);
    end
endmodule

// File: rtl/irq_addr_stack.sv
module irq_addr_stack
    import irq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pc_t  push_data,
    input  logic pop,
    output pc_t  top_data,
    output logic empty,
    output logic ovf
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    pc_t              mem [DEPTH];
    logic [CNT_W-1:0] sp_q;
    logic [CNT_W-1:0] sp_m1;
    logic             ovf_q;

    assign sp_m1    = sp_q - 1'b1;
    assign top_data = mem[sp_m1[IDX_W-1:0]];
    assign empty    = (sp_q == '0);
    assign ovf      = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            ovf_q <= 1'b0;
        end else if (push) begin
            if (sp_q < FULL) begin
                mem[sp_q[IDX_W-1:0]] <= push_data;
                sp_q <= sp_q + 1'b1;
            end else begin
                ovf_q <= 1'b1;
            end
        end else if (pop && !empty) begin
            sp_q <= sp_m1;
        end
    end

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    p_depth_bound_r9: assert property (@(posedge clk) disable iff (rst)
        sp_q <= FULL);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  boundary,
    input  logic  multi,
    input  logic  reti,
    input  logic  ei,
    input  pc_t   next_pc,
    input  base_t ibase,
    input  pick_t pick,
    input  logic  stk_empty,
    input  pc_t   stk_top,
    output logic  kill,
    output logic  push,
    output pc_t   push_addr,
    output logic  pc_load,
    output pc_t   pc_new,
    output logic  gie,
    output logic  stk_pop
);
    seq_st_t   st_q;
    logic      gie_q;
    call_ctx_t ctx_q;
    pc_t       ret_q;
    logic      idle;
    logic      take;

    assign idle    = (st_q == ST_IDLE);
    assign take    = idle && boundary && !multi && !reti && gie_q && pick.valid;
    assign stk_pop = idle && reti && !stk_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            gie_q <= 1'b0;
            ctx_q <= '0;
            ret_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (reti) begin
                        gie_q <= 1'b1;
                        if (!stk_empty) begin
                            ret_q <= stk_top;
                            st_q  <= ST_RET;
                        end
                    end else if (take) begin
                        ctx_q.ret <= next_pc;
                        ctx_q.vec <= build_vector(ibase, pick.kind);
                        gie_q     <= 1'b0;
                        st_q      <= ST_CALL_A;
                    end else if (ei) begin
                        gie_q <= 1'b1;
                    end
                end
                ST_CALL_A: st_q <= ST_CALL_B;
                ST_CALL_B: st_q <= ST_IDLE;
                ST_RET:    st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        kill      = (st_q == ST_CALL_A);
        push      = (st_q == ST_CALL_A);
        push_addr = ctx_q.ret;
        pc_load   = (st_q == ST_CALL_B) || (st_q == ST_RET);
        pc_new    = (st_q == ST_RET) ? ret_q : ctx_q.vec;
        gie       = gie_q;
    end

    p_call_two_r6: assert property (@(posedge clk) disable iff (rst)
        push |=> (pc_load && !push));
    p_gie_low_in_call_r7: assert property (@(posedge clk) disable iff (rst)
        push |-> !gie_q);
    p_take_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> $past(gie_q));
    p_ret_sets_gie_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RET) |-> gie_q);
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
#(
    parameter int unsigned STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic [N_SRC-1:0]  irq_mask,
    input  logic              insn_boundary,
    input  logic              insn_multi,
    input  logic              reti,
    input  logic              ei,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [BASE_W-1:0] ibase,
    output logic              insn_kill,
    output logic              push_strobe,
    output logic [PC_W-1:0]   push_addr,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_new,
    output logic              gie,
    output logic              stk_ovf
);
    pick_t pick;
    logic  stk_empty;
    logic  stk_pop;
    pc_t   stk_top;

    irq_sampler u_smp (
        .clk  (clk),
        .rst  (rst),
        .req  (irq_req),
        .mask (irq_mask),
        .pick (pick)
    );

    irq_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .boundary  (insn_boundary),
        .multi     (insn_multi),
        .reti      (reti),
        .ei        (ei),
        .next_pc   (next_pc),
        .ibase     (ibase),
        .pick      (pick),
        .stk_empty (stk_empty),
        .stk_top   (stk_top),
        .kill      (insn_kill),
        .push      (push_strobe),
        .push_addr (push_addr),
        .pc_load   (pc_load),
        .pc_new    (pc_new),
        .gie       (gie),
        .stk_pop   (stk_pop)
    );

    irq_addr_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push_strobe),
        .push_data (push_addr),
        .pop       (stk_pop),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .ovf       (stk_ovf)
    );

    p_kill_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        insn_kill |-> $past(insn_boundary && !insn_multi));
endmodule

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;
    import irq_pkg::*;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_SRC-1:0]  irq_req = '0;
    logic [N_SRC-1:0]  irq_mask = '1;
    logic insn_boundary = 1'b0, insn_multi = 1'b0, reti = 1'b0, ei = 1'b0;
    logic [PC_W-1:0]   next_pc = '0;
    logic [BASE_W-1:0] ibase = '0;
    logic insn_kill, push_strobe, pc_load, gie, stk_ovf;
    logic [PC_W-1:0] push_addr, pc_new;

    always #4 clk = ~clk;

    irq_vector_unit #(.STACK_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_mask(irq_mask),
        .insn_boundary(insn_boundary), .insn_multi(insn_multi), .reti(reti),
        .ei(ei), .next_pc(next_pc), .ibase(ibase), .insn_kill(insn_kill),
        .push_strobe(push_strobe), .push_addr(push_addr), .pc_load(pc_load),
        .pc_new(pc_new), .gie(gie), .stk_ovf(stk_ovf)
    );

    int tests = 0;
    int fails = 0;
    int pushes = 0;
    int loads = 0;
    int last_pc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_st = 0;
    bit m_gie = 0, m_ovf = 0;
    int m_req = 0, m_ret = 0, m_vec = 0, m_pop = 0;
    int m_stk[$];

    always @(negedge clk) m_req = rst ? 0 : int'(irq_req);

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_gie = 0; m_ovf = 0; m_stk.delete();
        end else begin
            case (m_st)
                0: begin
                    int pend;
                    pend = m_req & int'(irq_mask);
                    if (reti) begin
                        m_gie = 1;
                        if (m_stk.size() > 0) begin
                            m_pop = m_stk.pop_back();
                            m_st = 3;
                        end
                    end else if (insn_boundary && !insn_multi && m_gie && pend != 0) begin
                        int k;
                        k = 0;
                        while (((pend >> k) & 1) == 0) k++;
                        m_ret = int'(next_pc);
                        m_vec = (int'(ibase) << 5) | (k << 2);
                        m_gie = 0;
                        m_st = 1;
                    end else if (ei) begin
                        m_gie = 1;
                    end
                end
                1: begin
                    if (m_stk.size() < DEPTH) m_stk.push_back(m_ret);
                    else m_ovf = 1;
                    m_st = 2;
                end
                default: m_st = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            chk(insn_kill == (m_st == 1), "R5", "insn_kill", insn_kill, m_st == 1);
            chk(push_strobe == (m_st == 1), "R5", "push_strobe", push_strobe, m_st == 1);
            if (m_st == 1)
                chk(int'(push_addr) == m_ret, "R5", "push_addr", push_addr, m_ret);
            chk(pc_load == (m_st == 2 || m_st == 3), (m_st == 3) ? "R8" : "R6",
                "pc_load", pc_load, m_st == 2 || m_st == 3);
            if (m_st == 2)
                chk(int'(pc_new) == m_vec, "R6", "pc_new vector", pc_new, m_vec);
            if (m_st == 3)
                chk(int'(pc_new) == m_pop, "R8", "pc_new return", pc_new, m_pop);
            chk(gie == m_gie, "R7", "gie", gie, m_gie);
            chk(stk_ovf == m_ovf, "R9", "stk_ovf", stk_ovf, m_ovf);
            if (push_strobe) pushes++;
            if (pc_load) begin loads++; last_pc = int'(pc_new); end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic enable_irq();
        ei = 1'b1; step(); ei = 1'b0; step();
    endtask

    task automatic take_once(input logic [7:0] req, input int addr, input int base);
        irq_req = req; next_pc = PC_W'(addr); ibase = BASE_W'(base);
        insn_boundary = 1'b1; step(); insn_boundary = 1'b0; step(4);
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0; step(3);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int p0;
        step(4);
        chk(!gie && !insn_kill && !push_strobe && !pc_load && !stk_ovf, "R1",
            "outputs in reset", {gie, insn_kill, push_strobe, pc_load, stk_ovf}, 0);
        rst = 1'b0; step();
        chk(!gie && !push_strobe && !pc_load && !stk_ovf, "R1", "after reset",
            {gie, push_strobe, pc_load, stk_ovf}, 0);

        // R3/R7: no take while gie is 0
        p0 = pushes;
        take_once(8'h01, 16'h0F00, 3);
        chk(pushes == p0, "R7", "take with gie low", pushes - p0, 0);

        // single source
        enable_irq();
        take_once(8'h20, 16'h1000, 11'h155);
        chk(last_pc == ((11'h155 << 5) | (5 << 2)), "R6", "vector src5", last_pc,
            (11'h155 << 5) | (5 << 2));

        // R4: masked lower source loses
        irq_mask = 8'hF7; enable_irq();
        take_once(8'h48, 16'h2000, 11'h0AA);
        chk(last_pc == ((11'h0AA << 5) | (6 << 2)), "R4", "masked src3", last_pc,
            (11'h0AA << 5) | (6 << 2));
        irq_mask = 8'hFF; enable_irq();
        take_once(8'h14, 16'h3000, 11'h001);
        chk(last_pc == ((11'h001 << 5) | (2 << 2)), "R4", "lowest wins", last_pc,
            (11'h001 << 5) | (2 << 2));

        // R3: mid-instruction boundary
        enable_irq(); p0 = pushes;
        insn_multi = 1'b1; take_once(8'h01, 16'h4000, 0); insn_multi = 1'b0;
        chk(pushes == p0, "R3", "multi boundary", pushes - p0, 0);

        // R2: pulse between falling and rising edge
        irq_req = '0; step(2); p0 = pushes;
        insn_boundary = 1'b1;
        @(negedge clk); #1 irq_req = 8'h01;
        @(posedge clk); #1 irq_req = '0;
        step(2); insn_boundary = 1'b0; step(3);
        chk(pushes == p0, "R2", "short pulse", pushes - p0, 0);

        // R8: LIFO return
        do_reti();
        chk(last_pc == 16'h3000, "R8", "pop order", last_pc, 16'h3000);
        chk(gie == 1'b1, "R8", "gie after reti", gie, 1);

        // R10: reti beats a qualifying boundary
        p0 = pushes;
        irq_req = 8'h02; insn_boundary = 1'b1; reti = 1'b1; step();
        reti = 1'b0; insn_boundary = 1'b0; step(3);
        chk(pushes == p0, "R10", "take during reti", pushes - p0, 0);
        chk(last_pc == 16'h2000, "R10", "return done", last_pc, 16'h2000);

        // R9: overflow
        for (int i = 0; i < 4; i++) begin
            enable_irq();
            take_once(8'h80, 16'h5000 + i * 16, 11'h100);
        end
        chk(stk_ovf == 1'b1, "R9", "overflow flag", stk_ovf, 1);
        step(3);
        chk(stk_ovf == 1'b1, "R9", "flag sticky", stk_ovf, 1);
        do_reti();
        chk(last_pc == 16'h5020, "R9", "dropped push", last_pc, 16'h5020);

        // R8: drain, then empty return only sets gie
        irq_req = '0;
        for (int i = 0; i < 3; i++) do_reti();
        chk(last_pc == 16'h1000, "R8", "oldest entry", last_pc, 16'h1000);
        p0 = loads;
        do_reti();
        chk(loads == p0, "R8", "empty reti load", loads - p0, 0);
        chk(gie == 1'b1, "R8", "empty reti gie", gie, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule